// File: doc/BRIEF.md
# Four-by-four systolic multiply-accumulate mesh

This block is a square mesh of sixteen multiply-accumulate cells that computes the product of two 4x4 matrices of unsigned 4-bit values. Each cell keeps a running 10-bit sum. Operands flow through the mesh from left to right and from top to bottom, one cell per clock. Every cell multiplies the pair of operands it captured on the previous edge and adds the product to its sum.

The operands are skewed at the edges of the mesh, and an external step counter does the skewing. Row `i` of the A matrix enters the left edge `i` steps late, and column `j` of the B matrix enters the top edge `j` steps late. The matching elements therefore meet in the right cell, and no outside delay lines are needed.

A controller outside this block runs each pass:

1. It pulses `clr`.
2. It holds `run` high while it steps `step_cnt` upward from zero.
3. It reads the sixteen sums from `acc_out` once the step for the far corner has completed.

Top module: `systolic_mac_mesh`

## Requirements
- R1: The mesh has 16 cells in 4 rows and 4 columns, with unsigned 4-bit operands and 10-bit sums. `a_mat[i][k]` is row i, column k of A, and `b_mat[k][j]` is row k, column j of B. After a full pass (`step_cnt` stepped 0 to 10 with `run` high after a clear), `acc_out[i][j]` equals the sum over k of `a_mat[i][k]*b_mat[k][j]`.
- R2: On each edge with `run` high and `clr` low, a cell captures its incoming operands and adds the product of the operands it held before the edge. A cell passes its held A operand to the cell on its right and its held B operand to the cell below, one edge per hop. As a result, after the edge that samples `step_cnt` = c, `acc_out[i][j]` holds the sum of `a_mat[i][k]*b_mat[k][j]` over every k with k <= c-i-j-1.
- R3: The left input of row i carries `a_mat[i][step_cnt-i]` when i <= `step_cnt` < i+4, and zero otherwise. The top input of column j carries `b_mat[step_cnt-j][j]` when j <= `step_cnt` < j+4, and zero otherwise.
- R4: `acc_out[i][j]` reaches its final value after the edge that samples `step_cnt` = i+j+4.
- R5: `clr` high zeroes every sum and every held operand on the next edge, whether or not `run` is high. After a clear, stepping with zero edge inputs leaves every sum at zero.
- R6: While `run` is low and `clr` is low, every cell holds its sum and its operands, whatever `step_cnt` and the operand inputs do.
- R7: No sum wraps for any 4-bit operands. With every operand at 15, each result is 900.
- R8: `rst_n` low clears every sum and every held operand at once, without waiting for a clock edge.
- R9: For `step_cnt` values above 10, stepping with `run` high leaves the finished sums unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all cells; overrides `run` |
| run | input | 1 | Advance the mesh by one step this edge |
| step_cnt | input | 4 | Step counter that drives the edge skew |
| a_mat | input | 4x4x4 | A matrix, indexed `[row][col]` |
| b_mat | input | 4x4x4 | B matrix, indexed `[row][col]` |
| acc_out | output | 4x4x10 | Sums of the cells, indexed `[row][col]` |

## Verification
The bench tries the mesh with five kinds of input:

- **Uniform-value sweep.** A and B are each filled with a single value, for all 256 value pairs. This sweep probes the multiplier and sum width everywhere, including the 900 ceiling.
- **One-hot A.** A holds a single nonzero element, set against a B whose entries are all distinct. Any mix-up of the row, column or skew indexing then lands a product in the wrong cell.
- **Arithmetic ramps and pseudo-random matrices.** These are checked on every step against the partial sums expected from the skew. They separate an off-by-one in hop delay or feed timing from correct operation.
- **Pauses in mid-stream.** These show that the mesh holds its state while `run` is low.
- **Clear and reset.** A clear or a reset issued in the middle of a pass shows that held operands are wiped along with the sums.

// File: rtl/mesh_pkg.sv
package mesh_pkg;

    localparam int MESH_N = 4;
    localparam int OP_W   = 4;
    localparam int ACC_W  = 10;

    // Steps needed for a full pass: the far corner finishes at 3N-2.
    function automatic int last_step(input int n);
        return 3 * n - 2;
    endfunction

    function automatic int step_width(input int n);
        return $clog2(3 * n);
    endfunction

endpackage

// File: rtl/edge_feed.sv
module edge_feed #(
    parameter int N     = 4,
    parameter int OPW   = 4,
    parameter int CNTW  = 4,
    parameter int IDX   = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNTW-1:0]          step_cnt,
    input  logic [N-1:0][OPW-1:0]    lane,
    output logic [OPW-1:0]           feed
);

    localparam logic [CNTW-1:0] FIRST = CNTW'(IDX);

    // Pick lane element k when the counter equals IDX+k, zero otherwise.
    always_comb begin
        feed = '0;
        for (int k = 0; k < N; k++) begin
            if (step_cnt == CNTW'(IDX + k)) begin
                feed = lane[k];
            end
        end
    end

    // R3: nothing enters this lane before its turn.
    a_r3_quiet_before: assert property (@(posedge clk) disable iff (!rst_n)
        (step_cnt < FIRST) |-> (feed == '0));

    // R3: nothing enters this lane once it has been consumed.
    a_r3_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
        (step_cnt >= CNTW'(IDX + N)) |-> (feed == '0));

endmodule

// File: rtl/mac_cell.sv
module mac_cell #(
    parameter int OPW  = 4,
    parameter int ACCW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    input  logic [OPW-1:0]  a_in,
    input  logic [OPW-1:0]  b_in,
    output logic [OPW-1:0]  a_fwd,
    output logic [OPW-1:0]  b_fwd,
    output logic [ACCW-1:0] acc
);

    typedef struct packed {
        logic [OPW-1:0]  a;
        logic [OPW-1:0]  b;
        logic [ACCW-1:0] sum;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (run) begin
            st_d.a   = a_in;
            st_d.b   = b_in;
            st_d.sum = st_q.sum + ACCW'(st_q.a) * ACCW'(st_q.b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_fwd = st_q.a;
    assign b_fwd = st_q.b;
    assign acc   = st_q.sum;

    // R5: a clear empties the whole cell on the next edge.
    a_r5_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0 && a_fwd == '0 && b_fwd == '0));

    // R6: an idle cell holds everything.
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !run) |=> ($stable(acc) && $stable(a_fwd) && $stable(b_fwd)));

    // R7: a running sum never moves backwards, so it never wraps.
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (acc >= $past(acc)));

endmodule

// File: rtl/systolic_mac_mesh.sv
module systolic_mac_mesh
    import mesh_pkg::*;
#(
    parameter int N    = MESH_N,
    parameter int OPW  = OP_W,
    parameter int ACCW = ACC_W,
    parameter int CNTW = $clog2(3 * N)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             run,
    input  logic [CNTW-1:0]                  step_cnt,
    input  logic [N-1:0][N-1:0][OPW-1:0]     a_mat,
    input  logic [N-1:0][N-1:0][OPW-1:0]     b_mat,
    output logic [N-1:0][N-1:0][ACCW-1:0]    acc_out
);

    // a_h[r][c] enters cell (r,c) from the left; column N is the right edge.
    logic [N-1:0][N:0][OPW-1:0] a_h;
    // b_v[r][c] enters cell (r,c) from above; row N is the bottom edge.
    logic [N:0][N-1:0][OPW-1:0] b_v;

    for (genvar r = 0; r < N; r++) begin : g_row_feed
        edge_feed #(.N(N), .OPW(OPW), .CNTW(CNTW), .IDX(r)) u_row_feed (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_cnt (step_cnt),
            .lane     (a_mat[r]),
            .feed     (a_h[r][0])
        );
    end

    for (genvar c = 0; c < N; c++) begin : g_col_feed
        logic [N-1:0][OPW-1:0] col_lane;
        for (genvar k = 0; k < N; k++) begin : g_gather
            assign col_lane[k] = b_mat[k][c];
        end
        edge_feed #(.N(N), .OPW(OPW), .CNTW(CNTW), .IDX(c)) u_col_feed (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_cnt (step_cnt),
            .lane     (col_lane),
            .feed     (b_v[0][c])
        );
    end

    for (genvar r = 0; r < N; r++) begin : g_r
        for (genvar c = 0; c < N; c++) begin : g_c
            mac_cell #(.OPW(OPW), .ACCW(ACCW)) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .run   (run),
                .a_in  (a_h[r][c]),
                .b_in  (b_v[r][c]),
                .a_fwd (a_h[r][c+1]),
                .b_fwd (b_v[r+1][c]),
                .acc   (acc_out[r][c])
            );

            // R2: one edge per hop, rightward for A and downward for B.
            a_r2_hop_a: assert property (@(posedge clk) disable iff (!rst_n)
                (run && !clr) |=> (a_h[r][c+1] == $past(a_h[r][c])));
            a_r2_hop_b: assert property (@(posedge clk) disable iff (!rst_n)
                (run && !clr) |=> (b_v[r+1][c] == $past(b_v[r][c])));
        end
    end

    // R8: while reset is held, every sum reads zero.
    a_r8_reset_zero: assert property (@(posedge clk)
        !rst_n |-> (acc_out == '0));

endmodule

// File: tb/systolic_mac_mesh_bench.sv
module systolic_mac_mesh_bench;
    import mesh_pkg::*;

    localparam int N    = MESH_N;
    localparam int CW   = $clog2(3 * N);
    localparam int LAST = 3 * N - 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic clr   = 1'b0;
    logic run   = 1'b0;
    logic [CW-1:0] step_cnt = '0;
    logic [N-1:0][N-1:0][OP_W-1:0]  a_mat = '0;
    logic [N-1:0][N-1:0][OP_W-1:0]  b_mat = '0;
    logic [N-1:0][N-1:0][ACC_W-1:0] acc_out;

    int am [N][N];
    int bm [N][N];
    int errs   = 0;
    int checks = 0;
    bit finished = 1'b0;
    int seed = 12345;

    systolic_mac_mesh u_systolic_mac_mesh (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .run      (run),
        .step_cnt (step_cnt),
        .a_mat    (a_mat),
        .b_mat    (b_mat),
        .acc_out  (acc_out)
    );

    task automatic check(input string req, input int i, input int j,
                         input int got, input int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s cell[%0d][%0d] actual=%0d expected=%0d", req, i, j, got, exp);
        end
    endtask

    function automatic int partial(input int i, input int j, input int c);
        int s = 0;
        for (int k = 0; k < N; k++) begin
            if (k <= c - i - j - 1) s += am[i][k] * bm[k][j];
        end
        return s;
    endfunction

    task automatic check_all(input string req, input int c);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                check(req, i, j, int'(acc_out[i][j]), partial(i, j, c));
    endtask

    task automatic check_zero(input string req);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                check(req, i, j, int'(acc_out[i][j]), 0);
    endtask

    task automatic drive_mats();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                a_mat[i][k] = OP_W'(am[i][k]);
                b_mat[i][k] = OP_W'(bm[i][k]);
            end
    endtask

    // R5: clear with run also high and a live edge feed still empties the mesh.
    task automatic do_clear();
        clr = 1'b1; run = 1'b1; step_cnt = '0;
        @(negedge clk);
        clr = 1'b0; run = 1'b0;
        check_zero("R5");
    endtask

    task automatic stream(input int pause_at);
        drive_mats();
        do_clear();
        for (int c = 0; c <= LAST; c++) begin
            if (c == pause_at) begin
                run = 1'b0;
                for (int p = 0; p < 3; p++) begin
                    step_cnt = CW'(c + 3 + p);
                    @(negedge clk);
                    check_all("R6", c - 1);
                end
            end
            run = 1'b1;
            step_cnt = CW'(c);
            @(negedge clk);
            check_all("R2", c);
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (c == i + j + N) check("R4", i, j, int'(acc_out[i][j]), partial(i, j, LAST));
        end
        check_all("R1", LAST);
        for (int c = LAST + 1; c < (1 << CW); c++) begin
            step_cnt = CW'(c);
            @(negedge clk);
            check_all("R9", LAST);
        end
        run = 1'b0;
    endtask

    function automatic int next_rand();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return (seed >> 8) & 15;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        // R8: reset state
        @(negedge clk);
        check_zero("R8");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_zero("R8");

        // R7 and R1: uniform-value sweep including 15x15 -> 900
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                for (int i = 0; i < N; i++)
                    for (int k = 0; k < N; k++) begin
                        am[i][k] = a;
                        bm[i][k] = b;
                    end
                stream(-1);
                if (a == 15 && b == 15) check("R7", 3, 3, int'(acc_out[3][3]), 900);
            end

        // R1/R3: one-hot A against distinct B exposes index mapping
        for (int p = 0; p < N * N; p++) begin
            for (int i = 0; i < N; i++)
                for (int k = 0; k < N; k++) begin
                    am[i][k] = (i * N + k == p) ? 1 + (p % 15) : 0;
                    bm[i][k] = (i * N + k) % 16;
                end
            stream(-1);
        end

        // R2/R6: ramps with a pause mid-stream
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                am[i][k] = (i * N + k) % 16;
                bm[i][k] = 15 - ((k * N + i) % 16);
            end
        stream(5);

        // Pseudo-random matrices, pauses at varying steps
        for (int t = 0; t < 24; t++) begin
            for (int i = 0; i < N; i++)
                for (int k = 0; k < N; k++) begin
                    am[i][k] = next_rand();
                    bm[i][k] = next_rand();
                end
            stream((t % 3 == 0) ? 1 + (t % LAST) : -1);
        end

        // R5: clear mid-stream wipes held operands too
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                am[i][k] = 15;
                bm[i][k] = 15;
            end
        drive_mats();
        do_clear();
        run = 1'b1;
        for (int c = 0; c < 4; c++) begin
            step_cnt = CW'(c);
            @(negedge clk);
        end
        run = 1'b0;
        do_clear();
        run = 1'b1;
        step_cnt = '1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check_zero("R5");
        end
        run = 1'b0;

        // R8: reset mid-stream acts without an edge
        run = 1'b1;
        for (int c = 0; c < 5; c++) begin
            step_cnt = CW'(c);
            @(negedge clk);
        end
        run = 1'b0;
        rst_n = 1'b0;
        #1;
        check_zero("R8");
        @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;
        step_cnt = '1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check_zero("R8");
        end
        run = 1'b0;

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule